// File: doc/BRIEF.md
# Line write-permission controller with hold timer

This block manages a single cached line. Each cycle it decides what to do with a processor load, store or atomic request. It can grant a hit, issue a read or write permission request, or tell the requester to retry later. The line state lives in the block.

An outside token-counting unit moves the state when responses or grants arrive, using a forced-state input. That unit is out of scope here.

When the line enters one of the two hold states, a timer starts. The hold states are dirty-exclusive-hold and migratory-hold. While the timer runs, the line is kept for the local processor. When the timer expires, the line either leaves the hold state, or a starvation event is reported if another node holds a persistent lock on the address.

A configuration bit `no_mig` controls how atomics are treated. With it set, atomic requests form their own class. A line that was written only through atomics then ends in plain dirty-exclusive rather than migratory-exclusive. With it clear, an atomic behaves exactly like a store.

Top module: `tok_l1_wperm`

## Requirements
- R1: After reset the state is not-present (code 0) and `hit`, `retry`, `wr_req`, `rd_req` are low and `tmo_evt` is 0.
- R2: Request type codes are 0 load, 1 store, 2 atomic, 3 none. Type 3 is ignored: no output is asserted and the state holds. With `no_mig` clear, an atomic acts as a store in every state. At most one of `hit`, `retry`, `wr_req`, `rd_req` is high in a cycle.
- R3: A store or atomic raises `wr_req` and moves the state as follows:
  - not-present (0) or invalid (1) go to invalid-to-exclusive (8).
  - shared (2) goes to shared-to-exclusive (9).
  - owned (3) goes to owned-to-exclusive (10).
  - locked-invalid (12) goes to locked invalid-to-exclusive (14).
  - locked-shared (13) goes to locked shared-to-exclusive (16).
- R4: In any transient state, a valid request raises `retry` and leaves the state unchanged. The transient states are 8, 9, 10, invalid-to-shared (11), 14, locked invalid-to-shared (15) and 16.
- R5: In migratory-exclusive (5), a store hits and stays in 5. An atomic (with `no_mig` set) hits and moves the line to dirty-exclusive (4).
- R6: In dirty-exclusive (4), an atomic hits and stays in 4. A store hits and moves the line to 5.
- R7: In dirty-exclusive-hold (6), a store hits and moves the line to migratory-hold (7), while an atomic hits and stays in 6. In 7, both hit and stay.
- R8: A load hits in states 2, 3, 4, 5, 6, 7 and 13. A load in 0 or 1 raises `rd_req` and moves the line to 11. A load in 12 raises `rd_req` and moves the line to 15.
- R9: The timer expires in the HOLD_CYCLES-th cycle after the line enters state 6 or 7. Entry means either from outside those two states or through a forced state. Moving between 6 and 7 by request does not restart the timer. Expiry signals `tmo_evt` nonzero for exactly one cycle and does not repeat until the timer is restarted.
- R10: An expiry without a lock from another node gives `tmo_evt`=1. From 6 the line moves to 4. From 7 the line moves to 5, or to 4 when `no_mig` is set and the write request that allocated the entry was atomic.
- R11: An expiry while `lock_other` is high leaves the state unchanged. It gives `tmo_evt`=3 when `lock_write` is high and `tmo_evt`=2 otherwise.
- R12: The entry records an atomic flag when its write request was raised by an atomic. Every expiry frees the entry and clears the flag.
- R13: A forced state (`set_valid`) takes priority over an expiry, and an expiry takes priority over a request. A request that meets either of them raises `retry` and is not serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_mig | input | 1 | Keep atomic-only lines out of migratory state |
| req_valid | input | 1 | Processor request present |
| req_type | input | 2 | 0 load, 1 store, 2 atomic, 3 none |
| set_valid | input | 1 | Force the line state from the token unit |
| set_state | input | 5 | State to force |
| lock_other | input | 1 | Address persistently locked by another node |
| lock_write | input | 1 | That locker's access is a write |
| state | output | 5 | Current line state |
| hit | output | 1 | Request serviced as a hit |
| retry | output | 1 | Request recycled for a later retry |
| wr_req | output | 1 | Write permission request issued |
| rd_req | output | 1 | Read permission request issued |
| tmo_evt | output | 2 | Expiry event: 0 none, 1 no starver, 2 read starver, 3 write starver |

## Verification
The bench builds the block with HOLD_CYCLES=4. This makes every hold-timer expiry reachable a few cycles after a forced entry, so the exact expiry cycle can be checked against the idle cycles before it.

That short window also lets one run cover several expiries:
- the atomic-flag path;
- both starver codes;
- a restart of the timer from inside a hold state;
- an expiry that collides with a request.

// File: rtl/tok_l1_wperm.sv
module tok_l1_wperm #(
  parameter int HOLD_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       no_mig,
  input  logic       req_valid,
  input  logic [1:0] req_type,
  input  logic       set_valid,
  input  logic [4:0] set_state,
  input  logic       lock_other,
  input  logic       lock_write,
  output logic [4:0] state,
  output logic       hit,
  output logic       retry,
  output logic       wr_req,
  output logic       rd_req,
  output logic [1:0] tmo_evt
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  typedef enum logic [4:0] {
    ST_NOTP = 5'd0,  ST_INV  = 5'd1,  ST_SHR  = 5'd2,  ST_OWN  = 5'd3,
    ST_DEX  = 5'd4,  ST_MIG  = 5'd5,  ST_DEXH = 5'd6,  ST_MIGH = 5'd7,
    ST_I2X  = 5'd8,  ST_S2X  = 5'd9,  ST_O2X  = 5'd10, ST_I2S  = 5'd11,
    ST_INVL = 5'd12, ST_SHRL = 5'd13, ST_I2XL = 5'd14, ST_I2SL = 5'd15,
    ST_S2XL = 5'd16
  } st_t;

  st_t         cur, nxt;
  logic [CW-1:0] cnt;
  logic        aflag, aflag_nxt;

  wire cur_hold = (cur == ST_DEXH) || (cur == ST_MIGH);
  wire nxt_hold = (nxt == ST_DEXH) || (nxt == ST_MIGH);
  wire expire   = cur_hold && (cnt == CW'(1));
  wire live     = req_valid && (req_type != 2'd3);
  wire ld       = req_valid && (req_type == 2'd0);
  wire wr_cls   = req_valid && ((req_type == 2'd1) || (req_type == 2'd2 && !no_mig));
  wire at_cls   = req_valid && (req_type == 2'd2) && no_mig;
  wire is_at    = (req_type == 2'd2);

  assign state = cur;

  always_comb begin
    nxt       = cur;
    aflag_nxt = aflag;
    hit       = 1'b0;
    retry     = 1'b0;
    wr_req    = 1'b0;
    rd_req    = 1'b0;
    tmo_evt   = 2'd0;
    if (set_valid) begin
      nxt   = st_t'(set_state);
      retry = live;
    end else if (expire) begin
      retry     = live;
      aflag_nxt = 1'b0;
      if (lock_other) begin
        tmo_evt = lock_write ? 2'd3 : 2'd2;
      end else begin
        tmo_evt = 2'd1;
        if (cur == ST_MIGH && !(no_mig && aflag)) nxt = ST_MIG;
        else nxt = ST_DEX;
      end
    end else if (live) begin
      case (cur)
        ST_NOTP, ST_INV: begin
          if (ld) begin
            rd_req = 1'b1;
            nxt    = ST_I2S;
          end else begin
            wr_req    = 1'b1;
            nxt       = ST_I2X;
            aflag_nxt = is_at;
          end
        end
        ST_INVL: begin
          if (ld) begin
            rd_req = 1'b1;
            nxt    = ST_I2SL;
          end else begin
            wr_req    = 1'b1;
            nxt       = ST_I2XL;
            aflag_nxt = is_at;
          end
        end
        ST_SHR, ST_SHRL, ST_OWN: begin
          if (ld) begin
            hit = 1'b1;
          end else begin
            wr_req    = 1'b1;
            aflag_nxt = is_at;
            nxt = (cur == ST_SHR) ? ST_S2X : (cur == ST_OWN) ? ST_O2X : ST_S2XL;
          end
        end
        ST_DEX: begin
          hit = 1'b1;
          if (wr_cls) nxt = ST_MIG;
        end
        ST_MIG: begin
          hit = 1'b1;
          if (at_cls) nxt = ST_DEX;
        end
        ST_DEXH: begin
          hit = 1'b1;
          if (wr_cls) nxt = ST_MIGH;
        end
        ST_MIGH: hit = 1'b1;
        default: retry = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= ST_NOTP;
      aflag <= 1'b0;
      cnt   <= '0;
    end else begin
      cur   <= nxt;
      aflag <= aflag_nxt;
      if (nxt_hold && (!cur_hold || set_valid)) cnt <= CW'(HOLD_CYCLES);
      else if (nxt_hold && cnt != '0) cnt <= cnt - CW'(1);
      else if (!nxt_hold) cnt <= '0;
    end
  end
endmodule

module tok_l1_wperm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_valid,
  input logic       req_valid,
  input logic [1:0] req_type,
  input logic [4:0] state,
  input logic       hit,
  input logic       retry,
  input logic       wr_req,
  input logic       rd_req,
  input logic [1:0] tmo_evt
);
  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, retry, wr_req, rd_req}));

  assert_none_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd3 && !set_valid && tmo_evt == 2'd0) |=> $stable(state));

  assert_write_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (state == 5'd8 || state == 5'd9 || state == 5'd10 || state == 5'd14 || state == 5'd16));

  assert_retry_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && !set_valid && tmo_evt == 2'd0) |=> $stable(state));

  assert_evt_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt != 2'd0) |-> (state == 5'd6 || state == 5'd7));

  assert_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt != 2'd0 && !set_valid) |=> (tmo_evt == 2'd0));

  assert_nostarve_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt == 2'd1 && !set_valid) |=> (state == 5'd4 || state == 5'd5));

  assert_starver_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt[1] && !set_valid) |=> $stable(state));
endmodule

bind tok_l1_wperm tok_l1_wperm_chk chk (
  .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .req_valid(req_valid),
  .req_type(req_type), .state(state), .hit(hit), .retry(retry),
  .wr_req(wr_req), .rd_req(rd_req), .tmo_evt(tmo_evt)
);

// File: tb/tok_l1_wperm_test.sv
module tok_l1_wperm_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       no_mig = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_type = 2'd3;
  logic       set_valid = 1'b0;
  logic [4:0] set_state = 5'd0;
  logic       lock_other = 1'b0;
  logic       lock_write = 1'b0;
  logic [4:0] state;
  logic       hit, retry, wr_req, rd_req;
  logic [1:0] tmo_evt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [3:0] acts;
    logic [1:0] evt;
    logic [4:0] st;
  } item_t;

  item_t q[$];

  tok_l1_wperm #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .no_mig(no_mig), .req_valid(req_valid),
    .req_type(req_type), .set_valid(set_valid), .set_state(set_state),
    .lock_other(lock_other), .lock_write(lock_write), .state(state),
    .hit(hit), .retry(retry), .wr_req(wr_req), .rd_req(rd_req), .tmo_evt(tmo_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [1:0] rt, input logic sv, input logic [4:0] ss,
                      input logic lo, input logic lw, input logic [3:0] acts, input logic [1:0] evt,
                      input logic [4:0] st, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    req_valid = rv; req_type = rt; set_valid = sv; set_state = ss;
    lock_other = lo; lock_write = lw;
    it.tag = tag; it.acts = acts; it.evt = evt; it.st = st;
    q.push_back(it);
  endtask

  // acts = {hit, retry, wr_req, rd_req}
  task automatic force_st(input logic [4:0] s, input string tag);
    step(1'b0, 2'd3, 1'b1, s, 1'b0, 1'b0, 4'b0000, 2'd0, s, tag);
  endtask
  task automatic req(input logic [1:0] t, input logic [3:0] acts, input logic [4:0] st, input string tag);
    step(1'b1, t, 1'b0, 5'd0, 1'b0, 1'b0, acts, 2'd0, st, tag);
  endtask
  task automatic idle(input int n, input logic [4:0] st, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd0, st, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.tag, "actions", {4'b0, hit, retry, wr_req, rd_req}, {4'b0, it.acts});
        cmp(it.tag, "tmo_evt", {6'b0, tmo_evt}, {6'b0, it.evt});
        @(posedge clk);
        #1;
        cmp(it.tag, "state", {3'b0, state}, {3'b0, it.st});
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "reset state", {3'b0, state}, 8'd0);
    cmp("R1", "reset outputs", {4'b0, hit, retry, wr_req, rd_req}, 8'd0);
    cmp("R1", "reset evt", {6'b0, tmo_evt}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    idle(1, 5'd0, "R1 idle");
    req(2'd0, 4'b0001, 5'd11, "R8 load in notp");
    req(2'd1, 4'b0100, 5'd11, "R4 store in i2s");
    req(2'd2, 4'b0100, 5'd11, "R4 atomic in i2s");
    force_st(5'd1, "R13 force inv");
    req(2'd1, 4'b0010, 5'd8, "R3 store in inv");
    req(2'd0, 4'b0100, 5'd8, "R4 load in i2x");
    force_st(5'd2, "R13 force shr");
    req(2'd3, 4'b0000, 5'd2, "R2 none type ignored");
    req(2'd0, 4'b1000, 5'd2, "R8 load hit shr");
    req(2'd1, 4'b0010, 5'd9, "R3 store in shr");
    force_st(5'd3, "R13 force own");
    req(2'd2, 4'b0010, 5'd10, "R3 atomic in own");
    force_st(5'd12, "R13 force invl");
    req(2'd0, 4'b0001, 5'd15, "R8 load in invl");
    req(2'd1, 4'b0100, 5'd15, "R4 store in i2sl");
    force_st(5'd12, "R13 force invl");
    req(2'd1, 4'b0010, 5'd14, "R3 store in invl");
    force_st(5'd13, "R13 force shrl");
    req(2'd0, 4'b1000, 5'd13, "R8 load hit shrl");
    req(2'd1, 4'b0010, 5'd16, "R3 store in shrl");
    req(2'd2, 4'b0100, 5'd16, "R4 atomic in s2xl");

    force_st(5'd5, "R13 force mig");
    req(2'd1, 4'b1000, 5'd5, "R5 store hit mig");
    req(2'd2, 4'b1000, 5'd4, "R5 atomic hit mig");
    req(2'd2, 4'b1000, 5'd4, "R6 atomic hit dex");
    req(2'd1, 4'b1000, 5'd5, "R6 store hit dex");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd0, 5'd5, "R2 mode switch");
    no_mig = 1'b0;
    req(2'd2, 4'b1000, 5'd5, "R2 atomic as store in mig");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd0, 5'd5, "R2 mode switch");
    no_mig = 1'b1;

    force_st(5'd6, "R9 enter dexh");
    req(2'd2, 4'b1000, 5'd6, "R7 atomic hit dexh");
    req(2'd1, 4'b1000, 5'd7, "R7 store hit dexh");
    idle(1, 5'd7, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd1, 5'd5, "R10 store-entry migh expiry");
    idle(1, 5'd5, "R9 single pulse");

    force_st(5'd0, "R13 force notp");
    req(2'd2, 4'b0010, 5'd8, "R12 atomic write issue");
    force_st(5'd7, "R9 enter migh");
    req(2'd2, 4'b1000, 5'd7, "R7 atomic hit migh");
    req(2'd1, 4'b1000, 5'd7, "R7 store hit migh");
    idle(1, 5'd7, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd1, 5'd4, "R10 R12 atomic migh expiry");

    force_st(5'd6, "R9 enter dexh");
    idle(3, 5'd6, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd1, 5'd4, "R10 dexh expiry");

    force_st(5'd0, "R13 force notp");
    req(2'd2, 4'b0010, 5'd8, "R12 atomic write issue");
    force_st(5'd7, "R9 enter migh");
    idle(3, 5'd7, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b1, 1'b1, 4'b0000, 2'd3, 5'd7, "R11 write starver");
    idle(6, 5'd7, "R9 no repeat after expiry");
    force_st(5'd7, "R9 restart in migh");
    idle(3, 5'd7, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0000, 2'd1, 5'd5, "R12 flag cleared by expiry");

    force_st(5'd6, "R9 enter dexh");
    idle(3, 5'd6, "R9 no early expiry");
    step(1'b0, 2'd3, 1'b0, 5'd0, 1'b1, 1'b0, 4'b0000, 2'd2, 5'd6, "R11 read starver");

    force_st(5'd7, "R9 enter migh");
    idle(3, 5'd7, "R9 no early expiry");
    step(1'b1, 2'd1, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0100, 2'd1, 5'd5, "R13 expiry beats request");
    step(1'b1, 2'd0, 1'b1, 5'd2, 1'b0, 1'b0, 4'b0100, 2'd0, 5'd2, "R13 force beats request");
    req(2'd0, 4'b1000, 5'd2, "R8 load hit after force");

    idle(1, 5'd2, "end");
    set_valid = 1'b0; req_valid = 1'b0;
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule